// File: doc/BRIEF.md
# RTC Periodic-Interrupt Timer

This block is a real-time counter peripheral with a small 32-bit register bus. A 32-bit up-counter advances once per prescaled tick. The tick comes from one of four source strobes, and an optional two-stage prescaler can divide it by 32, by 512, or by both. A periodic-interrupt unit counts the same prescaled ticks. Each time the count reaches a programmed period, the unit raises a flag and, if enabled, an interrupt.

The counter, prescaler and period logic run on `rtc_clk`. The registers run on the bus clock `clk`. A programmed period crosses into the counter domain through a toggle handshake, and a status bit shows that handshake while it is running. Events come back to the bus domain the same way before the flag becomes visible. Source select and divider settings are accepted only while the counter is stopped, so the prescaler never sees them change while it runs. Software stops the counter, picks a source and divider, starts it, loads a period, and then services the flag with a write-one-to-clear.

Top module: `rtc_api_timer`

## Requirements
- R1: After reset, the control (0x4), status (0x8) and period (0x10) registers read 0, `count_o` is 0 and `irq` is low.
- R2: `count_o` increments by one per prescaled tick only while control bit 31 (run) is 1, and holds its value while run is 0.
- R3: Control bit 10 divides the selected source by 32, bit 11 divides it by 512, and both together divide it by 16384.
- R4: Control bits 13:12 select which `src_tick` bit feeds the prescaler. Value 1 is reserved and produces no counting, whatever the strobes do.
- R5: A control write made while run is already 1 leaves bits 13:12, 11 and 10 unchanged in readback and in the division actually applied.
- R6: With control bit 15 set and a nonzero period N, status bit 13 sets after every N prescaled ticks. A period of 0, or bit 15 clear, gives no events, and clearing bit 15 restarts the tick count from zero.
- R7: Writing 1 to status bit 13 clears the flag. Writing 0 leaves it set.
- R8: `irq` is high exactly when the flag is set and control bit 14 is 1.
- R9: After a write to 0x10, status bit 17 reads 1 until the period has reached the counter domain, and then returns to 0. Writes to 0x10 while bit 17 is 1 are ignored.
- R10: The control register reads back run, period enable, interrupt enable, source select and divider bits at their positions, and 0x10 reads back the accepted period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain synchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, one per accepted write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Periodic interrupt request |
| rtc_clk | input | 1 | Counter-domain clock |
| rtc_rst_n | input | 1 | Counter-domain synchronous reset, active low |
| src_tick | input | 4 | Tick strobes of the four sources, sampled on `rtc_clk` |
| count_o | output | CNT_W | Free-running counter value, `rtc_clk` domain |

## Verification
The bench builds the block with its default parameters: stage widths of 5 and 9 bits, a 32-bit counter and period, and two-flop synchronisers. The combined ratio of 16384 therefore takes 32768 source strobes to step the counter twice, which fits in the run. Both clocks come from one bench oscillator. This fixes the handshake latency, so the bench can predict cycle by cycle which period writes the busy window rejects. Period tests use small N (3 and 5), so the wrap, the restart after disabling and the period of 0 are each reached with a few dozen strobes.

// File: rtl/rtc_pkg.sv
// Package rtc_pkg: register offsets and bit positions shared by the
// timer's RTL. Assumes a byte-addressed bus carrying 32-bit words.
package rtc_pkg;
    localparam int OFF_CTRL = 'h04;
    localparam int OFF_STAT = 'h08;
    localparam int OFF_APIV = 'h10;

    localparam int CTRL_RUN    = 31;
    localparam int CTRL_API_EN = 15;
    localparam int CTRL_API_IE = 14;
    localparam int CTRL_SEL_LO = 12;
    localparam int CTRL_D512   = 11;
    localparam int CTRL_D32    = 10;

    localparam int STAT_BUSY = 17;
    localparam int STAT_FLAG = 13;

    // settings that may only change while the counter is stopped
    typedef struct packed {
        logic [1:0] sel;
        logic       d512;
        logic       d32;
    } rtc_cfg_t;
endpackage

// File: rtl/rtc_bit_sync.sv
// Module rtc_bit_sync: multi-flop synchroniser for one level or toggle bit.
// Assumes the input is a register output of another clock domain.
module rtc_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr_q;

    // shift the asynchronous bit through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], d_i};
    end

    assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rtc_div_stage.sv
// Module rtc_div_stage: one optional power-of-two divide stage of the
// prescaler. When enabled it passes every 2**LOG2-th input strobe; when
// disabled it passes strobes straight through. Its count is held at zero
// while the counter is stopped.
module rtc_div_stage #(
    parameter int LOG2 = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic en_i,
    input  logic tick_i,
    output logic tick_o
);
    logic [LOG2-1:0] cnt_q;

    // count strobes of this stage, cleared while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)    cnt_q <= '0;
        else if (en_i && tick_i) cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = en_i ? (tick_i & (&cnt_q)) : tick_i;
endmodule

// File: rtl/rtc_prescaler.sv
// Module rtc_prescaler: picks one source strobe and divides it through a
// chain of optional stages. Assumes cfg_i is quasi-static: it only changes
// while run_i is low.
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int DIV_A_LOG2   = 5,
    parameter int DIV_B_LOG2   = 9,
    parameter int RESERVED_SRC = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_i,
    input  rtc_cfg_t cfg_i,
    input  logic [3:0] src_tick,
    output logic     tick_o
);
    localparam int NSTAGE = 2;
    localparam int STAGE_LOG2 [NSTAGE] = '{DIV_A_LOG2, DIV_B_LOG2};

    logic [NSTAGE:0]   chain;
    logic [NSTAGE-1:0] stage_en;

    // choose the source strobe; the reserved source never ticks
    always_comb begin
        if (cfg_i.sel == 2'(RESERVED_SRC)) chain[0] = 1'b0;
        else                               chain[0] = src_tick[cfg_i.sel] & run_i;
    end

    assign stage_en = {cfg_i.d512, cfg_i.d32};

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        rtc_div_stage #(.LOG2(STAGE_LOG2[g])) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (run_i),
            .en_i   (stage_en[g]),
            .tick_i (chain[g]),
            .tick_o (chain[g+1])
        );
    end

    assign tick_o = chain[NSTAGE];

    assert_reserved_src_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.sel == 2'(RESERVED_SRC)) |-> !tick_o);
endmodule

// File: rtl/rtc_count_core.sv
// Module rtc_count_core: free-running counter and periodic-event counter in
// the counter clock domain. Emits one toggle of evt_tog_o per elapsed period.
// Assumes load_val_i is stable whenever load_i is high.
module rtc_count_core #(
    parameter int CNT_W = 32,
    parameter int API_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             api_run_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [API_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             evt_tog_o
);
    logic [CNT_W-1:0] count_q;
    logic [API_W-1:0] api_val_q;
    logic [API_W-1:0] api_cnt_q;
    logic             evt_q;

    // main counter steps on each prescaled tick
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (tick_i) count_q <= count_q + 1'b1;
    end

    // period counter: load, clear when idle, wrap and toggle at the period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            api_val_q <= '0;
            api_cnt_q <= '0;
            evt_q     <= 1'b0;
        end else if (load_i) begin
            api_val_q <= load_val_i;
            api_cnt_q <= '0;
        end else if (!api_run_i || api_val_q == '0) begin
            api_cnt_q <= '0;
        end else if (tick_i) begin
            if (api_cnt_q == api_val_q - 1'b1) begin
                api_cnt_q <= '0;
                evt_q     <= ~evt_q;
            end else begin
                api_cnt_q <= api_cnt_q + 1'b1;
            end
        end
    end

    assign count_o   = count_q;
    assign evt_tog_o = evt_q;

    assert_count_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(count_q));

    assert_period_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (api_val_q != '0) |-> (api_cnt_q < api_val_q));
endmodule

// File: rtl/rtc_api_timer.sv
// Module rtc_api_timer: top of the RTC timer. Holds the bus-domain registers,
// runs the period handshake and event return path, and instances the
// prescaler and counter core on rtc_clk. Assumes one write per bus_we cycle.
module rtc_api_timer
    import rtc_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int CNT_W        = 32,
    parameter int API_W        = 32,
    parameter int DIV_A_LOG2   = 5,
    parameter int DIV_B_LOG2   = 9,
    parameter int SYNC_STAGES  = 2,
    parameter int RESERVED_SRC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    input  logic              rtc_clk,
    input  logic              rtc_rst_n,
    input  logic [3:0]        src_tick,
    output logic [CNT_W-1:0]  count_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_APIV = ADDR_W'(OFF_APIV);

    // bus-domain state
    logic             cnt_en_q, api_en_q, api_ie_q;
    rtc_cfg_t         cfg_q;
    logic [API_W-1:0] apival_q;
    logic             req_tog_q;
    logic             flag_q;
    logic             evt_b, evt_b_d_q, ack_b;
    logic             busy, flag_set;
    logic             wr_ctrl, wr_stat, wr_apiv;

    // counter-domain state
    logic run_s, api_run_s, req_s, req_d_q, load;
    logic presc_tick, evt_tog;

    logic unused_ok;
    assign unused_ok = &{1'b0, bus_wdata};

    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
    assign wr_stat = bus_we && (bus_addr == A_STAT);
    assign wr_apiv = bus_we && (bus_addr == A_APIV);

    assign busy     = req_tog_q ^ ack_b;
    assign flag_set = evt_b ^ evt_b_d_q;

    // control register; clock and divider fields locked while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en_q <= 1'b0;
            api_en_q <= 1'b0;
            api_ie_q <= 1'b0;
            cfg_q    <= '0;
        end else if (wr_ctrl) begin
            cnt_en_q <= bus_wdata[CTRL_RUN];
            api_en_q <= bus_wdata[CTRL_API_EN];
            api_ie_q <= bus_wdata[CTRL_API_IE];
            if (!cnt_en_q) begin
                cfg_q.sel  <= bus_wdata[CTRL_SEL_LO +: 2];
                cfg_q.d512 <= bus_wdata[CTRL_D512];
                cfg_q.d32  <= bus_wdata[CTRL_D32];
            end
        end
    end

    // period shadow and request toggle; writes during a handoff are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            apival_q  <= '0;
            req_tog_q <= 1'b0;
        end else if (wr_apiv && !busy) begin
            apival_q  <= bus_wdata[API_W-1:0];
            req_tog_q <= ~req_tog_q;
        end
    end

    // flag: set by a returned event, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q    <= 1'b0;
            evt_b_d_q <= 1'b0;
        end else begin
            evt_b_d_q <= evt_b;
            if (flag_set)                            flag_q <= 1'b1;
            else if (wr_stat && bus_wdata[STAT_FLAG]) flag_q <= 1'b0;
        end
    end

    // register read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[CTRL_RUN]          = cnt_en_q;
            bus_rdata[CTRL_API_EN]       = api_en_q;
            bus_rdata[CTRL_API_IE]       = api_ie_q;
            bus_rdata[CTRL_SEL_LO +: 2]  = cfg_q.sel;
            bus_rdata[CTRL_D512]         = cfg_q.d512;
            bus_rdata[CTRL_D32]          = cfg_q.d32;
        end else if (bus_addr == A_STAT) begin
            bus_rdata[STAT_BUSY] = busy;
            bus_rdata[STAT_FLAG] = flag_q;
        end else if (bus_addr == A_APIV) begin
            bus_rdata[API_W-1:0] = apival_q;
        end
    end

    assign irq = flag_q & api_ie_q;

    // bus to counter domain crossings
    rtc_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_run (
        .clk(rtc_clk), .rst_n(rtc_rst_n), .d_i(cnt_en_q), .q_o(run_s));
    rtc_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_api (
        .clk(rtc_clk), .rst_n(rtc_rst_n), .d_i(api_en_q), .q_o(api_run_s));
    rtc_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
        .clk(rtc_clk), .rst_n(rtc_rst_n), .d_i(req_tog_q), .q_o(req_s));

    // request edge detect; the delayed copy doubles as the acknowledge
    always_ff @(posedge rtc_clk) begin
        if (!rtc_rst_n) req_d_q <= 1'b0;
        else            req_d_q <= req_s;
    end
    assign load = req_s ^ req_d_q;

    // counter to bus domain crossings
    rtc_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk), .rst_n(rst_n), .d_i(req_d_q), .q_o(ack_b));
    rtc_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_evt (
        .clk(clk), .rst_n(rst_n), .d_i(evt_tog), .q_o(evt_b));

    rtc_prescaler #(
        .DIV_A_LOG2   (DIV_A_LOG2),
        .DIV_B_LOG2   (DIV_B_LOG2),
        .RESERVED_SRC (RESERVED_SRC)
    ) u_presc (
        .clk      (rtc_clk),
        .rst_n    (rtc_rst_n),
        .run_i    (run_s),
        .cfg_i    (cfg_q),
        .src_tick (src_tick),
        .tick_o   (presc_tick)
    );

    rtc_count_core #(
        .CNT_W (CNT_W),
        .API_W (API_W)
    ) u_core (
        .clk        (rtc_clk),
        .rst_n      (rtc_rst_n),
        .run_i      (run_s),
        .api_run_i  (api_run_s),
        .tick_i     (presc_tick),
        .load_i     (load),
        .load_val_i (apival_q),
        .count_o    (count_o),
        .evt_tog_o  (evt_tog)
    );

    assert_busy_drops_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_apiv && busy) |=> $stable(apival_q));

    assert_cfg_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && cnt_en_q) |=> $stable(cfg_q));

    assert_flag_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[STAT_FLAG] && !flag_set) |=> !flag_q);
endmodule

// File: tb/tb_rtc_api_timer.sv
module tb_rtc_api_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [3:0]  src_tick = '0;
    logic [31:0] count_o;

    always #5 clk = ~clk;

    rtc_api_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .rtc_clk(clk), .rtc_rst_n(rst_n), .src_tick(src_tick), .count_o(count_o)
    );

    // behavioural reference state
    logic [31:0] m_count, m_api_val, m_api_cnt;
    int          m_a, m_b, m_busy;
    logic [1:0]  m_sel;
    logic        m_run, m_api_en, m_ie, m_d32, m_d512, m_flag, m_t;

    int n_clk_cmp = 0, n_clk_bad = 0;
    int n_chk = 0, n_bad = 0;
    string cur_req = "R2";

    // reference model: decodes bus writes and source strobes at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 0; m_api_val = 0; m_api_cnt = 0; m_a = 0; m_b = 0; m_busy = 0;
            m_sel = 0; m_run = 0; m_api_en = 0; m_ie = 0; m_d32 = 0; m_d512 = 0; m_flag = 0;
        end else begin
            if (bus_we) begin
                if (bus_addr == 8'h04) begin
                    if (!m_run) begin
                        m_sel = bus_wdata[13:12]; m_d512 = bus_wdata[11]; m_d32 = bus_wdata[10];
                    end
                    m_run = bus_wdata[31]; m_api_en = bus_wdata[15]; m_ie = bus_wdata[14];
                    if (!m_run) begin m_a = 0; m_b = 0; end
                    if (!m_api_en) m_api_cnt = 0;
                end else if (bus_addr == 8'h08) begin
                    if (bus_wdata[13]) m_flag = 0;
                end else if (bus_addr == 8'h10) begin
                    if (m_busy == 0) begin
                        m_api_val = bus_wdata; m_api_cnt = 0; m_busy = 6;
                    end
                end
            end
            if (m_busy > 0) m_busy = m_busy - 1;
            m_t = (m_sel == 2'd1) ? 1'b0 : src_tick[m_sel];
            if (!m_run) m_t = 0;
            if (m_t && m_d32) begin
                m_a = m_a + 1;
                if (m_a == 32) m_a = 0; else m_t = 0;
            end
            if (m_t && m_d512) begin
                m_b = m_b + 1;
                if (m_b == 512) m_b = 0; else m_t = 0;
            end
            if (m_t) m_count = m_count + 1;
            if (m_t && m_api_en && m_api_val != 0) begin
                m_api_cnt = m_api_cnt + 1;
                if (m_api_cnt == m_api_val) begin m_api_cnt = 0; m_flag = 1; end
            end
        end
    end

    // per-clock comparison of the counter against the model
    always @(negedge clk) begin
        if (rst_n) begin
            n_clk_cmp = n_clk_cmp + 1;
            if (count_o !== m_count) begin
                n_clk_bad = n_clk_bad + 1;
                $display("FAIL %s count_o: actual %0d expected %0d", cur_req, count_o, m_count);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic burst(input logic [3:0] mask, input int n);
        @(negedge clk); src_tick = mask;
        repeat (n) @(negedge clk);
        src_tick = '0;
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_ctrl();
        logic [31:0] v = '0;
        v[31] = m_run; v[15] = m_api_en; v[14] = m_ie;
        v[13:12] = m_sel; v[11] = m_d512; v[10] = m_d32;
        return v;
    endfunction

    task automatic finish_run(input int extra_bad);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                 n_clk_cmp + n_chk + extra_bad, n_clk_bad + n_bad + extra_bad);
        $finish;
    endtask

    localparam logic [31:0] RUN = 32'h8000_0000, APE = 32'h0000_8000, AIE = 32'h0000_4000;
    localparam logic [31:0] D32 = 32'h0000_0400, D512 = 32'h0000_0800;

    initial begin
        #(10 * 150000);
        $display("FAIL watchdog: run did not complete");
        finish_run(1);
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cur_req = "R1";
        rd(8'h04, r); check("R1 ctrl", r, 32'h0);
        rd(8'h08, r); check("R1 stat", r, 32'h0);
        rd(8'h10, r); check("R1 period", r, 32'h0);
        check("R1 count", count_o, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 counting and hold; R10 readback
        cur_req = "R2";
        wr(8'h04, RUN); settle();
        burst(4'b0001, 10); settle();
        check("R2 count after 10 ticks", count_o, 32'd10);
        rd(8'h04, r); check("R10 ctrl readback", r, exp_ctrl());
        wr(8'h04, 32'h0); settle();
        burst(4'b0001, 5); settle();
        check("R2 count held while stopped", count_o, 32'd10);

        // R3 divide by 32 on source 2; R4 other source ignored
        cur_req = "R3";
        wr(8'h04, (32'd2 << 12) | D32);
        wr(8'h04, RUN | (32'd2 << 12) | D32); settle();
        rd(8'h04, r); check("R10 ctrl sel/div readback", r, RUN | (32'd2 << 12) | D32);
        burst(4'b0100, 64); settle();
        check("R3 divide by 32", count_o, 32'd12);
        cur_req = "R4";
        burst(4'b0001, 50); settle();
        check("R4 unselected source ignored", count_o, 32'd12);

        // R5 config writes ignored while running
        cur_req = "R5";
        wr(8'h04, RUN); settle();
        rd(8'h04, r); check("R5 cfg locked readback", r, RUN | (32'd2 << 12) | D32);
        burst(4'b0100, 32); settle();
        check("R5 division unchanged", count_o, 32'd13);

        // R4 reserved source
        cur_req = "R4";
        wr(8'h04, 32'h0);
        wr(8'h04, 32'd1 << 12);
        wr(8'h04, RUN | (32'd1 << 12)); settle();
        burst(4'b1111, 40); settle();
        check("R4 reserved source no count", count_o, 32'd13);

        // R3 divide by 512 on source 3, then both stages
        cur_req = "R3";
        wr(8'h04, 32'h0);
        wr(8'h04, (32'd3 << 12) | D512);
        wr(8'h04, RUN | (32'd3 << 12) | D512); settle();
        burst(4'b1000, 1024); settle();
        check("R3 divide by 512", count_o, 32'd15);
        wr(8'h04, 32'h0);
        wr(8'h04, D512 | D32);
        wr(8'h04, RUN | D512 | D32); settle();
        burst(4'b0001, 16383); settle();
        check("R3 one strobe short of 16384", count_o, 32'd15);
        burst(4'b0001, 16385); settle();
        check("R3 divide by 16384", count_o, 32'd17);

        // R9 handoff busy and dropped write
        cur_req = "R9";
        wr(8'h04, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h04, RUN | APE | AIE); settle();
        wr(8'h10, 32'd5);
        rd(8'h08, r); check("R9 busy after period write", r & (32'h1 << 17), 32'h1 << 17);
        wr(8'h10, 32'd9);
        settle();
        rd(8'h08, r); check("R9 busy returns to 0", r & (32'h1 << 17), 32'h0);
        rd(8'h10, r); check("R9 write during busy dropped", r, 32'd5);

        // R6 period events; R8 irq
        cur_req = "R6";
        burst(4'b0001, 4); settle();
        rd(8'h08, r); check("R6 no flag before period", r, {18'b0, m_flag, 13'b0});
        check("R6 flag clear after 4 of 5", {31'b0, m_flag}, 32'h0);
        burst(4'b0001, 1); settle();
        rd(8'h08, r); check("R6 flag after 5 ticks", r, 32'h1 << 13);
        check("R8 irq with enable", {31'b0, irq}, 32'h1);

        // R7 clear semantics; R8 gating
        cur_req = "R7";
        wr(8'h08, 32'h0);
        rd(8'h08, r); check("R7 write 0 keeps flag", r, 32'h1 << 13);
        wr(8'h04, RUN | APE); @(negedge clk);
        check("R8 irq masked by enable", {31'b0, irq}, {31'b0, m_flag & m_ie});
        wr(8'h08, 32'h1 << 13);
        rd(8'h08, r); check("R7 write 1 clears flag", r, 32'h0);
        wr(8'h04, RUN | APE | AIE);
        check("R8 irq low after clear", {31'b0, irq}, 32'h0);

        // R6 repeated periods, zero period
        cur_req = "R6";
        burst(4'b0001, 10); settle();
        rd(8'h08, r); check("R6 flag after two periods", r, 32'h1 << 13);
        wr(8'h08, 32'h1 << 13);
        wr(8'h10, 32'd0); settle();
        burst(4'b0001, 20); settle();
        rd(8'h08, r); check("R6 zero period gives no event", r, 32'h0);

        // R6 disabling restarts the tick count
        wr(8'h10, 32'd3); settle();
        burst(4'b0001, 2); settle();
        wr(8'h04, RUN | AIE); settle();
        burst(4'b0001, 10); settle();
        rd(8'h08, r); check("R6 no event while disabled", r, 32'h0);
        wr(8'h04, RUN | APE | AIE); settle();
        burst(4'b0001, 2); settle();
        rd(8'h08, r); check("R6 count restarted after disable", r, 32'h0);
        burst(4'b0001, 1); settle();
        rd(8'h08, r); check("R6 event after full period", r, 32'h1 << 13);
        check("R8 irq after restart event", {31'b0, irq}, 32'h1);
        check("R2 final count", count_o, m_count);

        finish_run(0);
    end
endmodule